// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Miss Classification

This block is a read-only byte cache for 32-bit byte addresses. It holds 16 lines of 32 bytes each, which is 512 bytes of data storage. Every line has a presence bit, a stored tag and its data words. A requester presents an address through a valid/ready handshake. The block answers with one byte, a hit flag and a two-bit code that tells what kind of miss, if any, the access caused.

On a miss the block sends the aligned line address to a simple memory port. That port returns eight 32-bit words, one per accepted beat. The block writes the words into its data store, records the new tag, and returns the requested byte once the last word has arrived. Each line also keeps the tag it most recently gave up. With this history a miss can be labelled compulsory (line empty), conflict (the evicted tag is coming back) or other replacement.

Top module: `bcache_top`

## Requirements
- R1: The address is split into tag = bits 31:9 (23 bits), line index = bits 8:5 (4 bits) and byte offset = bits 4:0 (5 bits).
- R2: After reset every line is empty, so the first access to any index is a miss.
- R3: An access is a hit exactly when the indexed line is present and its stored tag equals the address tag.
- R4: A miss pulses `mem_req` for one cycle with `mem_line_addr` equal to address bits 31:5. After the eighth fill word the line is present and holds the new tag.
- R5: A hit issues no memory request and leaves the line state unchanged, so a repeat of the same access hits again.
- R6: The returned byte is the one at the byte offset within the line. Fill word k holds line bytes 4k..4k+3, little-endian: byte 4k+j is in bits 8j+7:8j.
- R7: `rsp_miss_type` is 2'b00 on a hit and 2'b01 on a miss to an empty line. `rsp_hit` is high exactly when the code is 2'b00.
- R8: A miss whose tag equals the tag most recently evicted from the same line reports 2'b10 (conflict).
- R9: Any other miss to a present line reports 2'b11.
- R10: Whenever a present line is refilled, its old tag becomes that line's recorded evicted tag. Refilling an empty line leaves the record unchanged.
- R11: `req_ready` is high only when the block is idle and goes low from acceptance until the response. `rsp_valid` is a one-cycle pulse. A hit answers two cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Byte address of the request |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 8 | Returned byte |
| rsp_hit | output | 1 | Access hit |
| rsp_miss_type | output | 2 | 00 hit, 01 compulsory, 10 conflict, 11 other |
| mem_req | output | 1 | One-cycle line fetch request |
| mem_line_addr | output | 27 | Line address (byte address bits 31:5) |
| mem_rvalid | input | 1 | Fill word valid |
| mem_rdata | input | 32 | Fill word, line words in ascending order |

## Verification
The conflict code is the hardest response to reach. It needs a line that has been filled, then displaced by a second tag, and then asked again for the first tag. Other refills in between can replace the evicted-tag record. The bench walks through this by alternating tags on one index. It then runs a pseudo-random stream that uses only four tags over four indices, so that all three miss codes occur many times. A reference model computes the expected codes from the requirement rules alone.

// File: rtl/bcache_pkg.sv
package bcache_pkg;
  parameter int ADDR_W     = 32;
  parameter int LINE_BYTES = 32;
  parameter int NUM_LINES  = 16;
  parameter int WORD_W     = 32;

  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int TAG_W      = ADDR_W - OFF_W - IDX_W;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WPL        = LINE_BYTES / WORD_BYTES;
  localparam int WSEL_W     = $clog2(WPL);
  localparam int LADDR_W    = ADDR_W - OFF_W;
  localparam int RAM_AW     = IDX_W + WSEL_W;

  typedef enum logic [1:0] {
    MT_NONE     = 2'b00,
    MT_COLD     = 2'b01,
    MT_CONFLICT = 2'b10,
    MT_OTHER    = 2'b11
  } miss_t;
endpackage

// File: rtl/bcache_tags.sv
module bcache_tags
  import bcache_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             line_vld,
  output logic [TAG_W-1:0] line_tag,
  output logic             ev_vld,
  output logic [TAG_W-1:0] ev_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [NUM_LINES-1:0] vld_q;
  logic [NUM_LINES-1:0] evv_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  logic [TAG_W-1:0]     evt_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      evv_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
      if (vld_q[wr_idx]) evv_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      if (vld_q[wr_idx]) evt_q[wr_idx] <= tag_q[wr_idx];
    end
  end

  assign line_vld = vld_q[rd_idx];
  assign line_tag = tag_q[rd_idx];
  assign ev_vld   = evv_q[rd_idx];
  assign ev_tag   = evt_q[rd_idx];
endmodule

// File: rtl/bcache_data.sv
module bcache_data
  import bcache_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [RAM_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [RAM_AW-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = NUM_LINES * WPL;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bcache_ctrl.sv
module bcache_ctrl
  import bcache_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               rsp_hit,
  output logic [1:0]         rsp_miss_type,
  output logic               mem_req,
  output logic [LADDR_W-1:0] mem_line_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic [IDX_W-1:0]   look_idx,
  input  logic               line_vld,
  input  logic [TAG_W-1:0]   line_tag,
  input  logic               ev_vld,
  input  logic [TAG_W-1:0]   ev_tag,
  output logic               tag_we,
  output logic [TAG_W-1:0]   tag_wval,
  output logic [RAM_AW-1:0]  ram_raddr,
  input  logic [WORD_W-1:0]  ram_rdata,
  output logic               ram_we,
  output logic [RAM_AW-1:0]  ram_waddr
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_FILL} state_t;

  localparam logic [WSEL_W-1:0] LAST_W = WSEL_W'(WPL - 1);

  state_t              state_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [WSEL_W-1:0]   cnt_q;
  logic [7:0]          byte_q;
  miss_t               mt_q;

  logic [TAG_W-1:0]    a_tag;
  logic [WSEL_W-1:0]   a_wsel;
  logic [BSEL_W-1:0]   a_bsel;
  logic                hit;
  miss_t               mt_cls;
  logic                fill_beat;

  function automatic logic [7:0] pick(input logic [WORD_W-1:0] w,
                                      input logic [BSEL_W-1:0] b);
    return w[8*b +: 8];
  endfunction

  assign a_tag    = addr_q[ADDR_W-1 -: TAG_W];
  assign look_idx = addr_q[OFF_W +: IDX_W];
  assign a_wsel   = addr_q[BSEL_W +: WSEL_W];
  assign a_bsel   = addr_q[BSEL_W-1:0];

  assign hit = line_vld && (line_tag == a_tag);

  always_comb begin
    if (!line_vld)                      mt_cls = MT_COLD;
    else if (ev_vld && ev_tag == a_tag) mt_cls = MT_CONFLICT;
    else                                mt_cls = MT_OTHER;
  end

  assign req_ready = (state_q == S_IDLE);
  assign ram_raddr = {req_addr[OFF_W +: IDX_W], req_addr[BSEL_W +: WSEL_W]};
  assign fill_beat = (state_q == S_FILL) && mem_rvalid;
  assign ram_we    = fill_beat;
  assign ram_waddr = {look_idx, cnt_q};
  assign tag_we    = fill_beat && (cnt_q == LAST_W);
  assign tag_wval  = a_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      addr_q        <= '0;
      cnt_q         <= '0;
      byte_q        <= '0;
      mt_q          <= MT_NONE;
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_hit       <= 1'b0;
      rsp_miss_type <= 2'b00;
      mem_req       <= 1'b0;
      mem_line_addr <= '0;
    end else begin
      rsp_valid <= 1'b0;
      mem_req   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            state_q <= S_LOOK;
          end
        end
        S_LOOK: begin
          if (hit) begin
            rsp_valid     <= 1'b1;
            rsp_hit       <= 1'b1;
            rsp_miss_type <= MT_NONE;
            rsp_data      <= pick(ram_rdata, a_bsel);
            state_q       <= S_IDLE;
          end else begin
            mt_q          <= mt_cls;
            mem_req       <= 1'b1;
            mem_line_addr <= addr_q[ADDR_W-1:OFF_W];
            cnt_q         <= '0;
            state_q       <= S_FILL;
          end
        end
        S_FILL: begin
          if (mem_rvalid) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == a_wsel) byte_q <= pick(mem_rdata, a_bsel);
            if (cnt_q == LAST_W) begin
              rsp_valid     <= 1'b1;
              rsp_hit       <= 1'b0;
              rsp_miss_type <= mt_q;
              rsp_data      <= (cnt_q == a_wsel) ? pick(mem_rdata, a_bsel) : byte_q;
              state_q       <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bcache_top.sv
module bcache_top
  import bcache_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               req_ready,
  output logic               rsp_valid,
  output logic [7:0]         rsp_data,
  output logic               rsp_hit,
  output logic [1:0]         rsp_miss_type,
  output logic               mem_req,
  output logic [LADDR_W-1:0] mem_line_addr,
  input  logic               mem_rvalid,
  input  logic [WORD_W-1:0]  mem_rdata
);
  logic [IDX_W-1:0]  look_idx;
  logic              line_vld, ev_vld, tag_we, ram_we;
  logic [TAG_W-1:0]  line_tag, ev_tag, tag_wval;
  logic [RAM_AW-1:0] ram_raddr, ram_waddr;
  logic [WORD_W-1:0] ram_rdata;

  bcache_ctrl ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_miss_type(rsp_miss_type),
    .mem_req(mem_req), .mem_line_addr(mem_line_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .look_idx(look_idx), .line_vld(line_vld), .line_tag(line_tag),
    .ev_vld(ev_vld), .ev_tag(ev_tag),
    .tag_we(tag_we), .tag_wval(tag_wval),
    .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr)
  );

  bcache_tags tags_i (
    .clk(clk), .rst(rst),
    .rd_idx(look_idx), .line_vld(line_vld), .line_tag(line_tag),
    .ev_vld(ev_vld), .ev_tag(ev_tag),
    .wr_en(tag_we), .wr_idx(look_idx), .wr_tag(tag_wval)
  );

  bcache_data data_i (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(mem_rdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: rtl/bcache_chk.sv
module bcache_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic [1:0] rsp_miss_type,
  input logic       mem_req
);
  a_r11_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_hit_code: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_hit == (rsp_miss_type == 2'b00)));

  a_r4_req_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  a_r11_busy_in_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);
endmodule

bind bcache_top bcache_chk chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss_type(rsp_miss_type),
  .mem_req(mem_req)
);

// File: tb/bcache_top_tb_top.sv
module bcache_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit, mem_req;
  logic [7:0]  rsp_data;
  logic [1:0]  rsp_miss_type;
  logic [26:0] mem_line_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int mreq_cnt = 0;
  logic [26:0] last_line = '0;

  bit          m_vld [16];
  bit          m_evv [16];
  logic [22:0] m_tag [16];
  logic [22:0] m_ev  [16];

  always #5 clk = ~clk;

  bcache_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_miss_type(rsp_miss_type), .mem_req(mem_req),
    .mem_line_addr(mem_line_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return 8'(a[7:0] + a[15:8] * 8'd7 + a[23:16] * 8'd3 + a[31:24] * 8'd13);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: words little-endian, gap of one cycle before word 5
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        logic [26:0] ln;
        ln = mem_line_addr;
        last_line = ln;
        mreq_cnt++;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          if (k == 5) begin
            mem_rvalid = 1'b0;
            @(negedge clk);
          end
          mem_rvalid = 1'b1;
          for (int j = 0; j < 4; j++)
            mem_rdata[8*j +: 8] = mem_byte({ln, 3'(k), 2'(j)});
          @(negedge clk);
        end
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic access(input logic [31:0] a);
    logic [3:0]  idx;
    logic [22:0] tg;
    bit          ehit;
    logic [1:0]  etype;
    int          m0, lat;
    idx = a[8:5];
    tg  = a[31:9];
    ehit = m_vld[idx] && (m_tag[idx] == tg);
    if (ehit)                                 etype = 2'b00;
    else if (!m_vld[idx])                     etype = 2'b01;
    else if (m_evv[idx] && m_ev[idx] == tg)   etype = 2'b10;
    else                                      etype = 2'b11;
    while (!req_ready) @(negedge clk);
    m0 = mreq_cnt;
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11 ready low after accept", req_ready, 0);
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(rsp_hit == ehit, "R3 hit flag", rsp_hit, ehit);
    chk(rsp_miss_type == etype, "R7/R8/R9 miss code", rsp_miss_type, etype);
    chk(rsp_data == mem_byte(a), "R6 returned byte", rsp_data, mem_byte(a));
    if (ehit) begin
      chk(mreq_cnt == m0, "R5 no memory request on hit", mreq_cnt - m0, 0);
      chk(lat == 2, "R11 hit latency", lat, 2);
    end else begin
      chk(mreq_cnt == m0 + 1, "R4 one memory request on miss", mreq_cnt - m0, 1);
      chk(last_line == a[31:5], "R1/R4 aligned line address", last_line, a[31:5]);
      if (m_vld[idx]) begin
        m_ev[idx]  = m_tag[idx];
        m_evv[idx] = 1'b1;
      end
      m_vld[idx] = 1'b1;
      m_tag[idx] = tg;
    end
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R11 response is one cycle", rsp_valid, 0);
  endtask

  function automatic logic [31:0] mk(input logic [22:0] t, input logic [3:0] i,
                                     input logic [4:0] o);
    return {t, i, o};
  endfunction

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_vld[i] = 0; m_evv[i] = 0; m_tag[i] = '0; m_ev[i] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R2 no response after reset", rsp_valid, 0);
    chk(mem_req == 1'b0, "R2 no fetch after reset", mem_req, 0);

    // R2: first touch of each index is compulsory
    for (int i = 0; i < 16; i++) access(mk(23'h0011D7, 4'(i), 5'(i * 3)));
    // R5/R6: every offset of every line hits
    for (int i = 0; i < 16; i++)
      for (int o = 0; o < 32; o++) access(mk(23'h0011D7, 4'(i), 5'(o)));
    // R8/R9/R10: alternate tags on one index
    access(mk(23'h0A47F0, 4'd2, 5'd20));  // other
    access(mk(23'h0011D7, 4'd2, 5'd15));  // conflict
    access(mk(23'h0A47F0, 4'd2, 5'd1));   // conflict
    access(mk(23'h7FFFFF, 4'd2, 5'd31));  // other, record becomes 0A47F0
    access(mk(23'h0011D7, 4'd2, 5'd0));   // other
    access(mk(23'h7FFFFF, 4'd2, 5'd9));   // conflict
    access(mk(23'h7FFFFF, 4'd2, 5'd10));  // hit
    // mixed stream: four tags over four indices
    begin
      logic [31:0] lf;
      logic [22:0] tags [4];
      tags[0] = 23'h000001; tags[1] = 23'h2AAAAA; tags[2] = 23'h555555; tags[3] = 23'h0C3C3C;
      lf = 32'hACE1_2468;
      for (int n = 0; n < 400; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        access(mk(tags[lf[3:2]], {2'b10, lf[9:8]}, lf[16:12]));
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule